// File: doc/BRIEF.md
# DMA Read-Back Sequencer

This block drives the read side of a DMA channel's single data port. A 7-bit selection mask picks which internal values the CPU can read back: the status byte, the two bytes of the transfer byte counter, and the two bytes of each of the two port address counters. When a sequence starts, the block packs the selected items into an ordered list. Each read strobe then returns the next item on that list. After the last item the list wraps back to the first. When no item is selected, every read returns the live status byte.

The status byte has fixed ones in bits 7, 6, 3 and 2. Its other bits report whether the channel is enabled, whether the ready input disagrees with the programmed ready polarity (this bit is only active outside byte mode), whether a match is still pending, and whether the end of block is still pending.

A small FSM holds the sequencer state. There are two states:
- `ST_EMPTY`: no item is selected, and reads return the status byte.
- `ST_ARMED`: a non-empty list is loaded.

Any start event takes one of two transitions:
- `T_ARM` enters `ST_ARMED` when the effective mask is non-zero.
- `T_DISARM` enters `ST_EMPTY` when the effective mask is zero.

A start event is a status command, a mask write or a sequence start. While in `ST_ARMED`, a read takes one of two transitions:
- `T_STEP` moves the pointer to the next entry.
- `T_WRAP` returns the pointer to entry 0 after the last entry.

Top module: `dma_readback_seq`

## Requirements
- R1: After reset `rd_data` is 0x38, the mask is zero and no sequence is armed.
- R2: The status byte is 0xCC, with bit0 set when `chan_en`=1, bit4 set when `match_hit`=0 and bit5 set when `end_hit`=0.
- R3: Status bit1 is set when `byte_mode`=0 and `ready_act` differs from `ready_pol`. Otherwise bit1 is clear.
- R4: `mask_wr` stores `mask_in` and starts a sequence. The list holds the selected items in ascending mask-bit order: bit0 status, bit1 byte counter low, bit2 byte counter high, bit3 port A low, bit4 port A high, bit5 port B low, bit6 port B high.
- R5: Any start event sets the read pointer to the first entry of the new list. `seq_start` rebuilds the list from the held mask.
- R6: Each `rd_stb` loads `rd_data` with the entry at the pointer on that clock edge and advances the pointer. After the last entry the pointer wraps to the first.
- R7: When the list is empty, each `rd_stb` loads the live status byte into `rd_data`.
- R8: `stat_cmd` forces the mask to 0x01 and restarts the sequence, so every following read returns status.
- R9: Counter bytes are taken from `byte_cnt`, `cnt_a` and `cnt_b` in the cycle of the read, not in the cycle of the start.
- R10: `rd_data` changes only on a cycle with `rd_stb` (or on reset).
- R11: Start priority is `stat_cmd` over `mask_wr` over `seq_start`. A read in the same cycle as a start is served from the list that was in place before that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_in | input | 7 | Selection mask for `mask_wr` |
| mask_wr | input | 1 | Store mask and start a sequence |
| seq_start | input | 1 | Restart the sequence with the held mask |
| stat_cmd | input | 1 | Force mask 0x01 and restart |
| rd_stb | input | 1 | CPU read strobe |
| chan_en | input | 1 | Channel enabled |
| byte_mode | input | 1 | Channel in byte mode |
| ready_act | input | 1 | Ready input level |
| ready_pol | input | 1 | Programmed ready polarity |
| match_hit | input | 1 | A match has occurred |
| end_hit | input | 1 | End of block has occurred |
| byte_cnt | input | 16 | Transfer byte counter |
| cnt_a | input | 16 | Port A address counter |
| cnt_b | input | 16 | Port B address counter |
| rd_data | output | 8 | Registered read data |

## Verification
The hardest case to reach is a start and a read in the same cycle while a sequence is part-way through. In that case the old list must serve the read while the new list resets the pointer. The stimulus first walks part of a full-mask sequence. It then issues combined read-and-start cycles, including ones where several start sources collide. A long pseudo-random phase follows, with counters that change every cycle so that stale sampling is exposed.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    localparam int SEL_N  = 7;                    // selectable items
    localparam int CODE_W = $clog2(SEL_N);        // item code width
    localparam int NUM_W  = $clog2(SEL_N + 1);    // count / pointer width

    typedef logic [CODE_W-1:0] sel_code_t;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_ARMED = 1'b1
    } rbs_state_e;

    // item codes; the code equals the mask bit that selects it
    localparam sel_code_t C_STATUS = 3'd0;
    localparam sel_code_t C_BC_LO  = 3'd1;
    localparam sel_code_t C_BC_HI  = 3'd2;
    localparam sel_code_t C_A_LO   = 3'd3;
    localparam sel_code_t C_A_HI   = 3'd4;
    localparam sel_code_t C_B_LO   = 3'd5;
    localparam sel_code_t C_B_HI   = 3'd6;
endpackage

// File: rtl/rbs_list_build.sv
module rbs_list_build
    import rbs_pkg::*;
(
    input  logic [SEL_N-1:0]             sel_mask,
    output sel_code_t [SEL_N-1:0]        list,
    output logic [NUM_W-1:0]             count
);
    // pack set bits of the mask into ascending order
    always_comb begin
        int n;
        n = 0;
        list = '0;
        for (int i = 0; i < SEL_N; i++) begin
            if (sel_mask[i]) begin
                list[n] = sel_code_t'(i);
                n = n + 1;
            end
        end
        count = NUM_W'(n);
    end
endmodule

// File: rtl/rbs_status_fmt.sv
module rbs_status_fmt #(
    parameter int DATA_W = 8
) (
    input  logic              chan_en,
    input  logic              byte_mode,
    input  logic              ready_act,
    input  logic              ready_pol,
    input  logic              match_hit,
    input  logic              end_hit,
    output logic [DATA_W-1:0] status
);
    localparam logic [DATA_W-1:0] BASE = DATA_W'(8'hCC);

    always_comb begin
        status    = BASE;
        status[0] = chan_en;
        status[1] = !byte_mode && (ready_act != ready_pol);
        status[4] = !match_hit;
        status[5] = !end_hit;
    end
endmodule

// File: rtl/rbs_byte_sel.sv
module rbs_byte_sel
    import rbs_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  sel_code_t          code,
    input  logic [DATA_W-1:0]  status,
    input  logic [CNT_W-1:0]   byte_cnt,
    input  logic [CNT_W-1:0]   cnt_a,
    input  logic [CNT_W-1:0]   cnt_b,
    output logic [DATA_W-1:0]  dout
);
    always_comb begin
        unique case (code)
            C_STATUS: dout = status;
            C_BC_LO:  dout = byte_cnt[DATA_W-1:0];
            C_BC_HI:  dout = byte_cnt[CNT_W-1:DATA_W];
            C_A_LO:   dout = cnt_a[DATA_W-1:0];
            C_A_HI:   dout = cnt_a[CNT_W-1:DATA_W];
            C_B_LO:   dout = cnt_b[DATA_W-1:0];
            C_B_HI:   dout = cnt_b[CNT_W-1:DATA_W];
            default:  dout = status;
        endcase
    end
endmodule

// File: rtl/dma_readback_seq.sv
module dma_readback_seq
    import rbs_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_N-1:0]   mask_in,
    input  logic               mask_wr,
    input  logic               seq_start,
    input  logic               stat_cmd,
    input  logic               rd_stb,
    input  logic               chan_en,
    input  logic               byte_mode,
    input  logic               ready_act,
    input  logic               ready_pol,
    input  logic               match_hit,
    input  logic               end_hit,
    input  logic [CNT_W-1:0]   byte_cnt,
    input  logic [CNT_W-1:0]   cnt_a,
    input  logic [CNT_W-1:0]   cnt_b,
    output logic [DATA_W-1:0]  rd_data
);
    localparam logic [DATA_W-1:0] RESET_DATA = DATA_W'(8'h38);
    localparam logic [SEL_N-1:0]  STAT_MASK  = SEL_N'(1);

    rbs_state_e            state_q, state_d;
    logic [SEL_N-1:0]      mask_q;
    sel_code_t [SEL_N-1:0] list_q;
    logic [NUM_W-1:0]      cnt_q;
    logic [NUM_W-1:0]      ptr_q;

    logic                  start;
    logic [SEL_N-1:0]      eff_mask;
    sel_code_t [SEL_N-1:0] new_list;
    logic [NUM_W-1:0]      new_count;
    logic [DATA_W-1:0]     status_byte;
    logic [DATA_W-1:0]     item_byte;
    logic                  at_last;

    // start source priority: status command, mask write, plain start
    assign start = stat_cmd || mask_wr || seq_start;
    always_comb begin
        if (stat_cmd)     eff_mask = STAT_MASK;
        else if (mask_wr) eff_mask = mask_in;
        else              eff_mask = mask_q;
    end

    rbs_list_build u_build (
        .sel_mask (eff_mask),
        .list     (new_list),
        .count    (new_count)
    );

    rbs_status_fmt #(.DATA_W(DATA_W)) u_status (
        .chan_en   (chan_en),
        .byte_mode (byte_mode),
        .ready_act (ready_act),
        .ready_pol (ready_pol),
        .match_hit (match_hit),
        .end_hit   (end_hit),
        .status    (status_byte)
    );

    rbs_byte_sel #(.DATA_W(DATA_W)) u_sel (
        .code     (list_q[ptr_q]),
        .status   (status_byte),
        .byte_cnt (byte_cnt),
        .cnt_a    (cnt_a),
        .cnt_b    (cnt_b),
        .dout     (item_byte)
    );

    assign at_last = (ptr_q == cnt_q - NUM_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (start && new_count != '0) state_d = ST_ARMED;      // T_ARM
            end
            ST_ARMED: begin
                if (start && new_count == '0) state_d = ST_EMPTY;      // T_DISARM
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // state register and sequencer storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            mask_q  <= '0;
            list_q  <= '0;
            cnt_q   <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                mask_q <= eff_mask;
                list_q <= new_list;
                cnt_q  <= new_count;
                ptr_q  <= '0;
            end else if (rd_stb && state_q == ST_ARMED) begin
                if (at_last) ptr_q <= '0;                  // T_WRAP
                else         ptr_q <= ptr_q + NUM_W'(1);   // T_STEP
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= RESET_DATA;
        end else if (rd_stb) begin
            unique case (state_q)
                ST_EMPTY: rd_data <= status_byte;
                ST_ARMED: rd_data <= item_byte;
                default:  rd_data <= status_byte;
            endcase
        end
    end
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker
    import rbs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              mask_wr,
    input logic              seq_start,
    input logic              stat_cmd,
    input logic [SEL_N-1:0]  mask_in,
    input logic              armed,
    input logic [NUM_W-1:0]  ptr_q,
    input logic [NUM_W-1:0]  cnt_q,
    input logic [SEL_N-1:0]  mask_q,
    input logic [DATA_W-1:0] status_byte,
    input logic [DATA_W-1:0] rd_data
);
    logic any_start;
    assign any_start = mask_wr || seq_start || stat_cmd;

    AST_HOLD_BETWEEN_READS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data)); // R10

    AST_PTR_BELOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (ptr_q < cnt_q)); // R6

    AST_START_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        any_start |=> (ptr_q == '0)); // R5

    AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rd_stb && !any_start && ptr_q == cnt_q - NUM_W'(1)) |=> (ptr_q == '0)); // R6

    AST_STATUS_CMD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        stat_cmd |=> (mask_q == SEL_N'(1) && cnt_q == NUM_W'(1))); // R8

    AST_EMPTY_GIVES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !armed) |=> (rd_data == $past(status_byte))); // R7

    AST_FIXED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte & DATA_W'(8'hCC)) == DATA_W'(8'hCC)); // R2

    AST_COUNT_MATCHES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !stat_cmd) |=> (32'(cnt_q) == $countones($past(mask_in)))); // R4
endmodule

bind dma_readback_seq rbs_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_stb      (rd_stb),
    .mask_wr     (mask_wr),
    .seq_start   (seq_start),
    .stat_cmd    (stat_cmd),
    .mask_in     (mask_in),
    .armed       (state_q == rbs_pkg::ST_ARMED),
    .ptr_q       (ptr_q),
    .cnt_q       (cnt_q),
    .mask_q      (mask_q),
    .status_byte (status_byte),
    .rd_data     (rd_data)
);

// File: tb/sim_dma_readback_seq.sv
module sim_dma_readback_seq;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  mask_in = '0;
    logic        mask_wr = 0, seq_start = 0, stat_cmd = 0, rd_stb = 0;
    logic        chan_en = 0, byte_mode = 0, ready_act = 0, ready_pol = 0;
    logic        match_hit = 0, end_hit = 0;
    logic [15:0] byte_cnt = '0, cnt_a = '0, cnt_b = '0;
    logic [7:0]  rd_data;

    int errors = 0;
    int checks = 0;
    bit running = 0;
    string cur_req = "R1";

    always #(PERIOD/2) clk = ~clk;

    dma_readback_seq u0 (
        .clk(clk), .rst_n(rst_n), .mask_in(mask_in), .mask_wr(mask_wr),
        .seq_start(seq_start), .stat_cmd(stat_cmd), .rd_stb(rd_stb),
        .chan_en(chan_en), .byte_mode(byte_mode), .ready_act(ready_act),
        .ready_pol(ready_pol), .match_hit(match_hit), .end_hit(end_hit),
        .byte_cnt(byte_cnt), .cnt_a(cnt_a), .cnt_b(cnt_b), .rd_data(rd_data)
    );

    // ---------------- reference model ----------------
    int       m_q[$];
    int       m_ptr;
    bit [6:0] m_mask;
    bit [7:0] m_data;

    function automatic bit [7:0] exp_status();
        bit [7:0] s;
        s = 8'hCC;
        if (chan_en) s = s + 8'h01;
        if (!byte_mode && (ready_act != ready_pol)) s = s + 8'h02;
        if (!match_hit) s = s + 8'h10;
        if (!end_hit) s = s + 8'h20;
        return s;
    endfunction

    function automatic bit [7:0] exp_item(int code);
        case (code)
            1: return byte_cnt[7:0];
            2: return byte_cnt[15:8];
            3: return cnt_a[7:0];
            4: return cnt_a[15:8];
            5: return cnt_b[7:0];
            6: return cnt_b[15:8];
            default: return exp_status();
        endcase
    endfunction

    task automatic rebuild();
        m_q.delete();
        for (int i = 0; i < 7; i++) if (m_mask[i]) m_q.push_back(i);
        m_ptr = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete(); m_ptr = 0; m_mask = '0; m_data = 8'h38;
        end else begin
            if (rd_stb) begin
                if (m_q.size() == 0) m_data = exp_status();
                else begin
                    m_data = exp_item(m_q[m_ptr]);
                    m_ptr++;
                    if (m_ptr >= m_q.size()) m_ptr = 0;
                end
            end
            if (stat_cmd)       begin m_mask = 7'h01;   rebuild(); end
            else if (mask_wr)   begin m_mask = mask_in; rebuild(); end
            else if (seq_start) rebuild();
        end
    end

    task automatic check(string req, bit [7:0] exp);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: rd_data actual=%02h expected=%02h at %0t", req, rd_data, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) if (running && rst_n) check(cur_req, m_data);

    // ---------------- stimulus helpers ----------------
    task automatic clr();
        mask_wr = 0; seq_start = 0; stat_cmd = 0; rd_stb = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); clr(); end
    endtask

    task automatic rd();
        @(negedge clk); clr(); rd_stb = 1;
    endtask

    task automatic wmask(bit [6:0] m);
        @(negedge clk); clr(); mask_in = m; mask_wr = 1;
    endtask

    task automatic bump();
        byte_cnt = byte_cnt + 16'h0103;
        cnt_a    = cnt_a + 16'h0211;
        cnt_b    = cnt_b - 16'h0127;
    endtask

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        byte_cnt = 16'hA1B2; cnt_a = 16'hC3D4; cnt_b = 16'hE5F6;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", 8'h38);                 // R1 reset value
        running = 1;

        // R1 / R7: no sequence armed, reads give status
        cur_req = "R7";
        rd(); idle(1);
        // R2: status bit patterns
        cur_req = "R2";
        byte_mode = 1;
        chan_en = 1; match_hit = 0; end_hit = 0; rd(); idle(1);
        chan_en = 0; match_hit = 1; end_hit = 0; rd(); idle(1);
        chan_en = 1; match_hit = 1; end_hit = 1; rd(); idle(1);
        // R3: ready vs polarity, byte mode masking
        cur_req = "R3";
        byte_mode = 0;
        for (int k = 0; k < 8; k++) begin
            {byte_mode, ready_act, ready_pol} = 3'(k);
            rd();
        end
        byte_mode = 0; ready_act = 1; ready_pol = 0;
        idle(1);

        // R4 / R6: full mask, ordered, with wrap
        cur_req = "R4";
        wmask(7'h7F);
        cur_req = "R6";
        for (int k = 0; k < 10; k++) rd();
        idle(1);
        // R9: counters change between reads
        cur_req = "R9";
        wmask(7'h7E);
        for (int k = 0; k < 8; k++) begin rd(); bump(); end
        idle(1);
        // R10: idle cycles hold output while inputs move
        cur_req = "R10";
        for (int k = 0; k < 4; k++) begin @(negedge clk); clr(); bump(); chan_en = ~chan_en; end

        // sparse mask
        cur_req = "R4";
        wmask(7'h2A);
        for (int k = 0; k < 5; k++) rd();
        // R5: restart mid-sequence with held mask
        cur_req = "R5";
        @(negedge clk); clr(); seq_start = 1;
        for (int k = 0; k < 3; k++) rd();
        // R11: read together with restart
        cur_req = "R11";
        @(negedge clk); clr(); rd_stb = 1; seq_start = 1;
        for (int k = 0; k < 3; k++) rd();
        @(negedge clk); clr(); rd_stb = 1; mask_in = 7'h50; mask_wr = 1; stat_cmd = 1;
        for (int k = 0; k < 3; k++) rd();
        @(negedge clk); clr(); mask_in = 7'h18; mask_wr = 1; seq_start = 1;
        for (int k = 0; k < 3; k++) rd();

        // R7: zero mask disarms
        cur_req = "R7";
        wmask(7'h00);
        for (int k = 0; k < 3; k++) begin rd(); match_hit = ~match_hit; end
        // R8: status command
        cur_req = "R8";
        wmask(7'h66);
        rd(); rd();
        @(negedge clk); clr(); stat_cmd = 1;
        for (int k = 0; k < 4; k++) begin rd(); end_hit = ~end_hit; end
        // R5: seq_start after status command keeps mask 0x01
        cur_req = "R5";
        @(negedge clk); clr(); seq_start = 1;
        rd(); rd();
        idle(1);

        // mixed pseudo-random phase
        cur_req = "R6";
        for (int k = 0; k < 400; k++) begin
            int r;
            @(negedge clk); clr();
            r = int'($urandom_range(0, 99));
            rd_stb    = (r < 60);
            mask_wr   = (r >= 90);
            seq_start = (r >= 85 && r < 92);
            stat_cmd  = (r == 99);
            mask_in   = 7'($urandom);
            {chan_en, byte_mode, ready_act, ready_pol, match_hit, end_hit} = 6'($urandom);
            byte_cnt = 16'($urandom); cnt_a = 16'($urandom); cnt_b = 16'($urandom);
        end
        idle(2);

        // R1: reset in the middle of a sequence
        cur_req = "R1";
        wmask(7'h7F); rd();
        @(negedge clk); clr(); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check("R1", 8'h38);
        rd(); idle(1);
        @(negedge clk);
        running = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule